// File: doc/BRIEF.md
# Horizontal Microcoded Control Sequencer

This block is the control unit of a small single-bus processor. It holds a control store of horizontal microinstructions. Each control word has one bit for each datapath strobe, and those bits leave the block with no decoding. A micro-program counter (micro-PC) steps through the store one word per clock.

The store holds two routines:
- A three-word routine that fetches an instruction. It also advances the program counter by four.
- A four-word routine that adds a memory operand, addressed by register 3, into register 1.

Two bits in a word change the sequencing:
- The wait bit freezes the micro-PC until the memory signals completion.
- The end bit sends the micro-PC back to the fetch routine.

After the last fetch word, the opcode of the fetched instruction picks the next address. The add opcode goes to the start of the add routine. Any other opcode goes back to fetch.

The sequencer has three states:
- `ST_BOOT`: entered on reset. All strobes are low.
- `ST_RUN`: the current word is issued.
- `ST_HOLD`: the current word is still issued, but the micro-PC is frozen for a memory wait.

It has these transitions:
- BOOT→RUN: the first clock after reset.
- RUN→HOLD and HOLD→HOLD: the wait bit is set and completion is low.
- RUN→RUN and HOLD→RUN: otherwise. In this case the micro-PC moves to its next address.

Top module: `ucode_seq`

## Requirements
- R1: While `rst_n` is low, and up to the first rising clock edge after it goes high, `upc` is 0 and `ctl` is all zeros.
- R2: At the first rising edge after reset release, the sequencer starts issuing word 0. From then on, `ctl` equals the word at address `upc`.
- R3: The `ctl` bits are as follows:
  - Bit 0: PC load. Bit 1: PC drive.
  - Bit 2: MAR load. Bit 3: memory read.
  - Bit 4: MDR drive. Bit 5: IR load.
  - Bit 6: Y load.
  - Bit 7: ALU B select. 1 selects the constant 4; 0 selects Y.
  - Bit 8: ALU add. Bit 9: Z load. Bit 10: Z drive.
  - Bit 11: R1 load. Bit 12: R1 drive. Bit 13: R3 drive.
  - Bit 14: wait for memory. Bit 15: end.
- R4: The seven words at addresses 0 to 6 are, in hex: 038E, 4441, 0030, 200C, 5040, 0310, 8C00.
- R5: If the issued word has bit 14 set and `mem_done` is low at a rising edge, then `upc` and `ctl` hold their values through that edge.
- R6: If a word with bit 14 set sees `mem_done` high at a rising edge, the micro-PC advances at that same edge.
- R7: Addresses 0, 1, 3, 4 and 5 advance to the next address when they are not stalled.
- R8: At address 2, the next address is 3 if `opcode` equals 5 (the add instruction) at that edge, and 0 for any other opcode.
- R9: A word with bit 15 set is followed by address 0.
- R10: `mem_done` has no effect while the issued word has bit 14 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 4 | Opcode field of the fetched instruction, sampled at address 2 |
| mem_done | input | 1 | Memory completion indication |
| ctl | output | 16 | Horizontal control word driving the datapath strobes |
| upc | output | 3 | Current micro-PC |

## Verification
The assertions assume that `opcode` and `mem_done` change only between clock edges. They also assume that the micro-PC never reaches address 7, which holds because no routine leads there. They do not assume that the memory ever responds. A stall can therefore last any length of time, and the hold property covers each cycle on its own. The stimulus drives inputs only on the falling edge. It keeps completion low for runs of different lengths at both wait words. It also raises completion while words without the wait bit are issued, which checks that those words ignore it.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;

    localparam int CW_W = 16;

    // strobe bit positions inside a control word
    localparam int B_PC_LD   = 0;
    localparam int B_PC_DRV  = 1;
    localparam int B_MAR_LD  = 2;
    localparam int B_MEM_RD  = 3;
    localparam int B_MDR_DRV = 4;
    localparam int B_IR_LD   = 5;
    localparam int B_Y_LD    = 6;
    localparam int B_SEL4    = 7;
    localparam int B_ALU_ADD = 8;
    localparam int B_Z_LD    = 9;
    localparam int B_Z_DRV   = 10;
    localparam int B_R1_LD   = 11;
    localparam int B_R1_DRV  = 12;
    localparam int B_R3_DRV  = 13;
    localparam int B_WAIT    = 14;
    localparam int B_END     = 15;

    localparam int FETCH_LAST = 2;
    localparam int ADD_ENTRY  = 3;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_t;

    function automatic logic [CW_W-1:0] bits(input int b);
        logic [CW_W-1:0] v;
        v = '0;
        v[b] = 1'b1;
        return v;
    endfunction

    // control store contents, one horizontal word per address
    function automatic logic [CW_W-1:0] uword(input int a);
        logic [CW_W-1:0] w;
        case (a)
            0: w = bits(B_PC_DRV) | bits(B_MAR_LD) | bits(B_MEM_RD)
                 | bits(B_SEL4) | bits(B_ALU_ADD) | bits(B_Z_LD);
            1: w = bits(B_Z_DRV) | bits(B_PC_LD) | bits(B_Y_LD) | bits(B_WAIT);
            2: w = bits(B_MDR_DRV) | bits(B_IR_LD);
            3: w = bits(B_R3_DRV) | bits(B_MAR_LD) | bits(B_MEM_RD);
            4: w = bits(B_R1_DRV) | bits(B_Y_LD) | bits(B_WAIT);
            5: w = bits(B_MDR_DRV) | bits(B_ALU_ADD) | bits(B_Z_LD);
            6: w = bits(B_Z_DRV) | bits(B_R1_LD) | bits(B_END);
            default: w = bits(B_END);
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ucseq_store.sv
module ucseq_store #(
    parameter int UPC_W = 3
) (
    input  logic [UPC_W-1:0]             addr,
    output logic [ucseq_pkg::CW_W-1:0]   word
);
    localparam int DEPTH = 2 ** UPC_W;

    logic [ucseq_pkg::CW_W-1:0] rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign rom[i] = ucseq_pkg::uword(i);
    end

    assign word = rom[addr];
endmodule

// File: rtl/ucseq_next.sv
module ucseq_next #(
    parameter int UPC_W   = 3,
    parameter int OPC_W   = 4,
    parameter int ADD_OPC = 5
) (
    input  logic [UPC_W-1:0]           upc,
    input  logic [ucseq_pkg::CW_W-1:0] word,
    input  logic                       mem_done,
    input  logic [OPC_W-1:0]           opcode,
    output logic [UPC_W-1:0]           nxt,
    output logic                       stall
);
    import ucseq_pkg::*;

    localparam logic [UPC_W-1:0] A_FETCH = '0;
    localparam logic [UPC_W-1:0] A_LAST  = UPC_W'(FETCH_LAST);
    localparam logic [UPC_W-1:0] A_ADD   = UPC_W'(ADD_ENTRY);
    localparam logic [OPC_W-1:0] OP_ADD  = OPC_W'(ADD_OPC);

    assign stall = word[B_WAIT] & ~mem_done;

    always_comb begin
        if (word[B_END]) begin
            nxt = A_FETCH;
        end else if (upc == A_LAST) begin
            nxt = (opcode == OP_ADD) ? A_ADD : A_FETCH;
        end else begin
            nxt = upc + 1'b1;
        end
    end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq #(
    parameter int UPC_W   = 3,
    parameter int OPC_W   = 4,
    parameter int ADD_OPC = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [OPC_W-1:0]           opcode,
    input  logic                       mem_done,
    output logic [ucseq_pkg::CW_W-1:0] ctl,
    output logic [UPC_W-1:0]           upc
);
    import ucseq_pkg::*;

    seq_state_t        state_q, state_d;
    logic [UPC_W-1:0]  upc_q, upc_d, upc_nxt;
    logic [CW_W-1:0]   word;
    logic              stall;

    ucseq_store #(.UPC_W(UPC_W)) u_store (
        .addr (upc_q),
        .word (word)
    );

    ucseq_next #(.UPC_W(UPC_W), .OPC_W(OPC_W), .ADD_OPC(ADD_OPC)) u_next (
        .upc      (upc_q),
        .word     (word),
        .mem_done (mem_done),
        .opcode   (opcode),
        .nxt      (upc_nxt),
        .stall    (stall)
    );

    // next-state and micro-PC selection
    always_comb begin
        state_d = state_q;
        upc_d   = upc_q;
        unique case (state_q)
            ST_BOOT: begin
                state_d = ST_RUN;
            end
            ST_RUN, ST_HOLD: begin
                if (stall) begin
                    state_d = ST_HOLD;
                end else begin
                    state_d = ST_RUN;
                    upc_d   = upc_nxt;
                end
            end
            default: begin
                state_d = ST_BOOT;
                upc_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            upc_q   <= '0;
        end else begin
            state_q <= state_d;
            upc_q   <= upc_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_RUN, ST_HOLD: ctl = word;
            default:         ctl = '0;
        endcase
    end

    assign upc = upc_q;
endmodule

// File: rtl/ucode_seq_chk.sv
module ucode_seq_chk #(
    parameter int UPC_W   = 3,
    parameter int OPC_W   = 4,
    parameter int ADD_OPC = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [OPC_W-1:0]           opcode,
    input logic                       mem_done,
    input logic [ucseq_pkg::CW_W-1:0] ctl,
    input logic [UPC_W-1:0]           upc
);
    import ucseq_pkg::*;

    localparam logic [UPC_W-1:0] A_LAST = UPC_W'(FETCH_LAST);
    localparam logic [UPC_W-1:0] A_ADD  = UPC_W'(ADD_ENTRY);
    localparam logic [OPC_W-1:0] OP_ADD = OPC_W'(ADD_OPC);

    // R1: quiet while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (ctl == '0 && upc == '0)
                else $error("reset outputs not quiet");
        end
    end

    // R5
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[B_WAIT] && !mem_done) |=> ($stable(upc) && $stable(ctl)));

    // R6 and R7: unstalled, non-end word outside the dispatch point steps by one
    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl != '0 && upc != A_LAST && !ctl[B_END] && !(ctl[B_WAIT] && !mem_done))
        |=> (upc == $past(upc) + 1'b1));

    // R8
    p_dispatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl != '0 && upc == A_LAST)
        |=> (upc == (($past(opcode) == OP_ADD) ? A_ADD : '0)));

    // R9
    p_end_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[B_END] |=> (upc == '0));

    // R3: the constant-4 select only appears together with an add
    p_sel_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[B_SEL4] |-> ctl[B_ALU_ADD]);
endmodule

bind ucode_seq ucode_seq_chk #(.UPC_W(UPC_W), .OPC_W(OPC_W), .ADD_OPC(ADD_OPC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .opcode   (opcode),
    .mem_done (mem_done),
    .ctl      (ctl),
    .upc      (upc)
);

// File: tb/ucode_seq_tb_top.sv
module ucode_seq_tb_top;

    localparam int NV = 21;

    // expected words, built from the bit map of R3 / R4
    localparam logic [15:0] W0 = 16'h038E;
    localparam logic [15:0] W1 = 16'h4441;
    localparam logic [15:0] W2 = 16'h0030;
    localparam logic [15:0] W3 = 16'h200C;
    localparam logic [15:0] W4 = 16'h5040;
    localparam logic [15:0] W5 = 16'h0310;
    localparam logic [15:0] W6 = 16'h8C00;

    typedef struct packed {
        logic [2:0]  eupc;
        logic [15:0] ectl;
        logic        md;
        logic [3:0]  op;
        logic [7:0]  req;
    } vec_t;

    // each row: outputs expected now, inputs applied before the next edge
    localparam vec_t VT [NV] = '{
        '{3'd0, W0, 1'b0, 4'd5, 8'd2},   // R2 first word
        '{3'd1, W1, 1'b0, 4'd5, 8'd7},   // R7 step, stall starts
        '{3'd1, W1, 1'b0, 4'd5, 8'd5},   // R5 hold
        '{3'd1, W1, 1'b1, 4'd5, 8'd5},   // R5 hold, release
        '{3'd2, W2, 1'b0, 4'd5, 8'd6},   // R6 advanced
        '{3'd3, W3, 1'b1, 4'd5, 8'd8},   // R8 add dispatch, R10 md ignored
        '{3'd4, W4, 1'b1, 4'd5, 8'd10},  // R10 still stepped
        '{3'd5, W5, 1'b0, 4'd5, 8'd6},   // R6 no stall when done high
        '{3'd6, W6, 1'b1, 4'd5, 8'd7},   // R7
        '{3'd0, W0, 1'b0, 4'd9, 8'd9},   // R9 end returns
        '{3'd1, W1, 1'b1, 4'd9, 8'd7},
        '{3'd2, W2, 1'b0, 4'd9, 8'd6},
        '{3'd0, W0, 1'b0, 4'd5, 8'd8},   // R8 other opcode back to fetch
        '{3'd1, W1, 1'b1, 4'd5, 8'd7},
        '{3'd2, W2, 1'b0, 4'd5, 8'd6},
        '{3'd3, W3, 1'b0, 4'd5, 8'd8},
        '{3'd4, W4, 1'b0, 4'd5, 8'd7},   // R5 stall at second wait word
        '{3'd4, W4, 1'b1, 4'd5, 8'd5},
        '{3'd5, W5, 1'b0, 4'd5, 8'd6},
        '{3'd6, W6, 1'b0, 4'd5, 8'd4},   // R4 last word
        '{3'd0, W0, 1'b0, 4'd5, 8'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  opcode = 4'd0;
    logic        mem_done = 1'b0;
    logic [15:0] ctl;
    logic [2:0]  upc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ucode_seq dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode   (opcode),
        .mem_done (mem_done),
        .ctl      (ctl),
        .upc      (upc)
    );

    task automatic check(input string tag, input logic [2:0] eu, input logic [15:0] ec);
        n_chk++;
        if (upc !== eu || ctl !== ec) begin
            n_bad++;
            $display("FAIL %s upc=%0d ctl=%h expected upc=%0d ctl=%h", tag, upc, ctl, eu, ec);
        end
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset held
        repeat (3) @(negedge clk);
        check("R1 in reset", 3'd0, 16'h0);
        rst_n = 1'b1;
        #1;
        check("R1 before first edge", 3'd0, 16'h0);
        @(posedge clk);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check($sformatf("R%0d row %0d", VT[i].req, i), VT[i].eupc, VT[i].ectl);
            mem_done = VT[i].md;
            opcode   = VT[i].op;
        end

        // long stall at the fetch wait word (R5)
        @(negedge clk);
        check("R7 to word1", 3'd1, W1);
        mem_done = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            check("R5 long stall", 3'd1, W1);
        end
        mem_done = 1'b1;
        @(negedge clk);
        check("R6 release", 3'd2, W2);
        mem_done = 1'b0;
        opcode = 4'd0;

        // mid-run reset: R1, then restart R2
        @(negedge clk);
        check("R8 opcode 0 returns", 3'd0, W0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async reset", 3'd0, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 after release", 3'd0, 16'h0);
        @(negedge clk);
        check("R2 restart word0", 3'd0, W0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule